// File: doc/BRIEF.md
# Multiply/Divide Unit with HI/LO Result Registers

This unit carries out 32-bit by 32-bit multiplication and division, signed or unsigned, and places the two halves of each result in a pair of architectural registers, HI and LO. A one-cycle `start` strobe presents an operation code together with two operands. The same strobe can also load HI or LO directly from the first operand. Both registers are always driven on the outputs. Any consumer that wants a finished result must wait while `busy` is high.

Multiplication passes through a pipelined array multiplier of `MUL_STAGES` register stages. Division uses a restoring radix-2 divider that produces one quotient bit per cycle. It works on operand magnitudes and then fixes the signs: the quotient is negated when the operand signs differ, and the remainder takes the dividend's sign. Division never traps. A divisor of zero and the signed case of the most negative value divided by minus one each give fixed results in a single cycle.

The controller has three states:
- `ST_IDLE`: nothing is in flight.
- `ST_MUL`: the controller waits for the multiplier's valid output, then returns to `ST_IDLE`.
- `ST_DIV`: the controller waits for the divider's done pulse, then returns to `ST_IDLE`.

From any state, an accepted start moves to `ST_MUL` for a multiply, to `ST_DIV` for a non-special divide, and to `ST_IDLE` for everything else. A start aborts whatever was running.

Top module: `mdu_hilo`

## Requirements
- R1: Op code 0 (signed multiply) writes bits [63:32] of the 64-bit product of the sign-extended operands to HI and bits [31:0] to LO.
- R2: Op code 1 (unsigned multiply) writes the 64-bit product of the zero-extended operands, split between HI and LO in the same way as R1.
- R3: Op code 2 (signed divide), when the divisor is neither zero nor in the R6 case, writes to LO the quotient truncated toward zero and to HI the remainder, whose sign matches the dividend.
- R4: Op code 3 (unsigned divide) with a non-zero divisor writes the unsigned quotient to LO and the remainder to HI.
- R5: A divide with a zero divisor writes the dividend to HI. LO becomes 0x00000001 for a signed divide of a negative dividend and 0xFFFFFFFF otherwise. The result is visible right after the start edge and `busy` stays low.
- R6: A signed divide of 0x80000000 by 0xFFFFFFFF writes 0x80000000 to LO and 0 to HI. The result is visible right after the start edge and `busy` stays low.
- R7: Op code 4 writes `opa` to HI only, and op code 5 writes `opa` to LO only. Both take effect at the start edge with `busy` low. Op codes 6 and 7 change nothing and do not abort.
- R8: `busy` is high for exactly `MUL_STAGES` cycles after a multiply start and for `WIDTH`+1 cycles after a divide start. HI and LO do not change while `busy` is high.
- R9: A start accepted while `busy` is high aborts the running operation, whose result is never written.
- R10: After reset HI and LO are 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 3 | Operation code (0 to 7, see R1 to R7) |
| opa | input | WIDTH | Multiplicand, dividend, or value to move |
| opb | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | High while a multiply or divide is in flight |
| hi | output | WIDTH | HI register |
| lo | output | WIDTH | LO register |

## Verification
The bench mixes random operands, including small and zero divisors and both sign combinations, with directed corner cases. The corner cases are a zero divisor with a negative and a non-negative dividend, the most-negative-by-minus-one quotient, remainders with negative dividends, and the all-ones unsigned product. A design that negated the remainder by the quotient sign would give HI the wrong sign. A design that ran the special divides through the iterator would raise `busy` or produce an overflowed quotient. For aborts, a divide is interrupted by a move-to-LO and by a multiply, and HI/LO are then watched well past the point where the stale divide would have finished. A missing flush of either datapath would overwrite the registers late.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_MULU = 3'd1,
        OP_DIV  = 3'd2,
        OP_DIVU = 3'd3,
        OP_MTHI = 3'd4,
        OP_MTLO = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } mdu_state_e;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               flush,
    input  logic               is_signed,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] out_prod
);
    localparam int PW = 2 * WIDTH;

    logic signed [WIDTH:0]  ext_a, ext_b;
    logic signed [PW+1:0]   wide;
    logic [PW-1:0]          pipe [STAGES];
    logic [STAGES-1:0]      vld;

    assign ext_a = $signed({is_signed & a[WIDTH-1], a});
    assign ext_b = $signed({is_signed & b[WIDTH-1], b});
    assign wide  = $signed((PW+2)'(ext_a)) * $signed((PW+2)'(ext_b));

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) pipe[0] <= wide[PW-1:0];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vld[0] <= 1'b0;
                else        vld[0] <= in_valid;
            end
        end else begin : g_next
            always_ff @(posedge clk) pipe[i] <= pipe[i-1];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     vld[i] <= 1'b0;
                else if (flush) vld[i] <= 1'b0;
                else            vld[i] <= vld[i-1];
            end
        end
    end

    assign out_valid = vld[STAGES-1];
    assign out_prod  = pipe[STAGES-1];

    // R9: a flush leaves at most the new entry in the pipe
    p_flush_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $countones(vld) <= 1);
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             load,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             done,
    output logic [WIDTH-1:0] quo,
    output logic [WIDTH-1:0] rem
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] dvs;
    logic [WIDTH:0]   shifted, trial;

    assign shifted = {rem, quo[WIDTH-1]};
    assign trial   = shifted - {1'b0, dvs};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
            quo  <= '0;
            rem  <= '0;
            dvs  <= '0;
        end else if (kill) begin
            done <= 1'b0;
            cnt  <= load ? CW'(WIDTH) : '0;
            if (load) begin
                quo <= dividend;
                rem <= '0;
                dvs <= divisor;
            end
        end else if (cnt != '0) begin
            cnt  <= cnt - CW'(1);
            done <= (cnt == CW'(1));
            if (!trial[WIDTH]) begin
                rem <= trial[WIDTH-1:0];
                quo <= {quo[WIDTH-2:0], 1'b1};
            end else begin
                rem <= shifted[WIDTH-1:0];
                quo <= {quo[WIDTH-2:0], 1'b0};
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R8: one quotient bit per cycle, counter steps down by one
    p_div_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill && cnt != '0) |=> cnt == $past(cnt) - CW'(1));
    // R8: the done pulse is followed by an idle divider
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !kill) |=> !done);
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
    parameter int WIDTH      = 32,
    parameter int MUL_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             busy,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    import mdu_pkg::*;

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    mdu_state_e       state, state_nx;
    mdu_op_e          opc;
    logic             accept, is_mul, is_div, sgn, div_zero, div_ovf, div_slow;
    logic             neg_q, neg_r;
    logic [WIDTH-1:0] mag_a, mag_b, quo, rem;
    logic [2*WIDTH-1:0] prod;
    logic             mul_valid, div_done;

    assign opc      = mdu_op_e'(op);
    assign accept   = start && (opc != OP_RSV6) && (opc != OP_RSV7);
    assign is_mul   = (opc == OP_MUL) || (opc == OP_MULU);
    assign is_div   = (opc == OP_DIV) || (opc == OP_DIVU);
    assign sgn      = (opc == OP_MUL) || (opc == OP_DIV);
    assign div_zero = (opb == '0);
    assign div_ovf  = (opc == OP_DIV) && (opa == MOST_NEG) && (opb == ALL_ONES);
    assign div_slow = is_div && !div_zero && !div_ovf;
    assign mag_a    = (sgn && opa[WIDTH-1]) ? -opa : opa;
    assign mag_b    = (sgn && opb[WIDTH-1]) ? -opb : opb;

    mdu_mul #(.WIDTH(WIDTH), .STAGES(MUL_STAGES)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(accept && is_mul), .flush(accept),
        .is_signed(sgn), .a(opa), .b(opb), .out_valid(mul_valid), .out_prod(prod)
    );

    mdu_div #(.WIDTH(WIDTH)) u_div (
        .clk(clk), .rst_n(rst_n), .kill(accept), .load(accept && div_slow),
        .dividend(mag_a), .divisor(mag_b), .done(div_done), .quo(quo), .rem(rem)
    );

    always_comb begin
        state_nx = state;
        if (accept) begin
            if (is_mul)        state_nx = ST_MUL;
            else if (div_slow) state_nx = ST_DIV;
            else               state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_MUL:  if (mul_valid) state_nx = ST_IDLE;
                ST_DIV:  if (div_done)  state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb busy = (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi    <= '0;
            lo    <= '0;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
        end else if (accept) begin
            neg_q <= sgn && (opa[WIDTH-1] ^ opb[WIDTH-1]);
            neg_r <= sgn && opa[WIDTH-1];
            if (opc == OP_MTHI) hi <= opa;
            if (opc == OP_MTLO) lo <= opa;
            if (is_div && div_zero) begin
                hi <= opa;
                lo <= (sgn && opa[WIDTH-1]) ? ONE : ALL_ONES;
            end else if (div_ovf) begin
                hi <= '0;
                lo <= MOST_NEG;
            end
        end else if (state == ST_MUL && mul_valid) begin
            {hi, lo} <= prod;
        end else if (state == ST_DIV && div_done) begin
            lo <= neg_q ? -quo : quo;
            hi <= neg_r ? -rem : rem;
        end
    end

    // R5: a zero divisor finishes at once with the dividend in HI
    p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == 3'd2 || op == 3'd3) && opb == '0) |=> (!busy && hi == $past(opa)));
    // R6: signed overflow quotient
    p_ovf_quot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd2 && opa == MOST_NEG && opb == ALL_ONES) |=> (lo == MOST_NEG && hi == '0 && !busy));
    // R7: move-to-HI leaves LO alone
    p_move_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd4) |=> (hi == $past(opa) && lo == $past(lo) && !busy));
    // R7: reserved codes change nothing
    p_rsv_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[2:1] == 2'b11) |=> ($stable(hi) && $stable(lo) && $stable(busy)));
    // R8: registers hold while an operation stays in flight
    p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (!busy || ($stable(hi) && $stable(lo))));
    // R8: a multiply start raises busy
    p_mul_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[2:1] == 2'b00) |=> busy);
endmodule

// File: tb/tb_mdu_hilo.sv
`timescale 1ns/1ps
module tb_mdu_hilo;
    localparam int W  = 32;
    localparam int MS = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = '0;
    logic [W-1:0] opa = '0, opb = '0;
    logic         busy;
    logic [W-1:0] hi, lo;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mdu_hilo #(.WIDTH(W), .MUL_STAGES(MS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .hi(hi), .lo(lo)
    );

    function automatic logic [63:0] model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        longint p;
        int q, r;
        case (o)
            3'd0: begin p = longint'($signed(a)) * longint'($signed(b)); return p; end
            3'd1: return {32'b0, a} * {32'b0, b};
            3'd2: begin
                if (b == 0) return {a, (a[31] ? 32'h1 : 32'hFFFF_FFFF)};
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'h0, 32'h8000_0000};
                q = $signed(a) / $signed(b);
                r = $signed(a) % $signed(b);
                return {r, q};
            end
            default: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                return {a % b, a / b};
            end
        endcase
    endfunction

    function automatic string tag(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        if (o >= 3'd2 && b == 0) return "R5";
        if (o == 3'd2 && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R6";
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] e;
        string t;
        int cyc;
        int exp_cyc;
        e = model(o, a, b);
        t = tag(o, a, b);
        pulse(o, a, b);
        cyc = 0;
        while (busy && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        if (o <= 3'd1)      exp_cyc = MS;
        else if (t == "R3" || t == "R4") exp_cyc = W + 1;
        else                exp_cyc = 0;
        check(t, "hi", hi, e[63:32]);
        check(t, "lo", lo, e[31:0]);
        check(exp_cyc == 0 ? t : "R8", "busy cycles", cyc, exp_cyc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] a, b, h0, l0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", "hi", hi, 0);
        check("R10", "lo", lo, 0);
        check("R10", "busy", {31'b0, busy}, 0);

        // directed corners
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(3'd0, 32'h8000_0000, 32'h7FFF_FFFF);
        run_op(3'd2, 32'hFFFF_FFF9, 32'd2);
        run_op(3'd2, 32'd7, 32'hFFFF_FFFE);
        run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op(3'd2, 32'd5, 32'd0);
        run_op(3'd2, 32'hFFFF_FFF0, 32'd0);
        run_op(3'd2, 32'd0, 32'd0);
        run_op(3'd3, 32'h8000_0000, 32'd0);
        run_op(3'd3, 32'hFFFF_FFFF, 32'd1);
        run_op(3'd3, 32'h8000_0000, 32'hFFFF_FFFF);

        // R7 moves
        pulse(3'd4, 32'hA5A5_0001, 32'h0);
        check("R7", "mthi hi", hi, 32'hA5A5_0001);
        check("R7", "mthi busy", {31'b0, busy}, 0);
        l0 = lo;
        check("R7", "mthi lo kept", lo, l0);
        h0 = hi;
        pulse(3'd5, 32'h0BAD_F00D, 32'h0);
        check("R7", "mtlo lo", lo, 32'h0BAD_F00D);
        check("R7", "mtlo hi kept", hi, h0);
        pulse(3'd6, 32'h1111_1111, 32'h2222_2222);
        check("R7", "op6 hi", hi, h0);
        check("R7", "op6 lo", lo, 32'h0BAD_F00D);
        check("R7", "op6 busy", {31'b0, busy}, 0);

        // R7: reserved code during a divide does not abort it
        pulse(3'd3, 32'd1000, 32'd7);
        repeat (3) @(negedge clk);
        pulse(3'd7, 32'h3, 32'h4);
        while (busy) @(negedge clk);
        check("R7", "op7 no abort lo", lo, 32'd142);
        check("R7", "op7 no abort hi", hi, 32'd6);

        // R9 abort a divide with a move-to-LO
        h0 = hi;
        pulse(3'd3, 32'd100, 32'd7);
        repeat (5) @(negedge clk);
        check("R8", "hi held while busy", hi, h0);
        pulse(3'd5, 32'h0000_1234, 32'h0);
        check("R9", "abort busy", {31'b0, busy}, 0);
        repeat (40) @(negedge clk);
        check("R9", "abort lo", lo, 32'h0000_1234);
        check("R9", "abort hi", hi, h0);

        // R9 abort a divide with a multiply
        pulse(3'd2, 32'hFFFF_0000, 32'd3);
        repeat (3) @(negedge clk);
        run_op(3'd0, 32'd3, 32'd5);
        repeat (40) @(negedge clk);
        check("R9", "mul after abort lo", lo, 32'd15);
        check("R9", "mul after abort hi", hi, 32'd0);

        // R9 restart a multiply with another multiply
        pulse(3'd1, 32'd9, 32'd9);
        pulse(3'd1, 32'd4, 32'd6);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R9", "mul restart lo", lo, 32'd24);

        // random mix
        for (int i = 0; i < 200; i++) begin
            logic [2:0] o;
            o = 3'($urandom_range(0, 3));
            a = $urandom;
            b = $urandom;
            case ($urandom_range(0, 5))
                0: b = b % 17;
                1: b = -(b % 9);
                2: a = a % 1000;
                default: ;
            endcase
            run_op(o, a, b);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule